// File: doc/BRIEF.md
# Pointer-Addressed Double-Buffered DAC Register Bank

This block holds the code registers of a multi-channel DAC controller. Register accesses use a 4-bit address and 16-bit data. A separate global pointer picks one subsystem and one channel inside it. Every address on the register port then lands in that subsystem's 16-entry window. Addresses 0x0 and 0x1 reach the staging buffers A and B of the channel the pointer names.

Each channel has two staging buffers. Each buffer feeds its own live register, and the live register drives a 12-bit code output. In immediate mode a buffer write reaches the live register at the same clock edge. In strobed mode the live registers wait for a load strobe, and that strobe updates every channel of the subsystem at once.

A per-subsystem clear bit forces all outputs of the subsystem to zero. A per-subsystem square-wave enable makes each channel's output alternate between its A and B live codes, stepping once on each toggle strobe.

Top module: `dac_regbank`

## Requirements
- R1: The pointer is loaded only through `ptr_wr`/`ptr_wdata`. Bits 13:12 hold the subsystem number and bits 4:0 hold the channel number. A register write to address 0x6 has no effect. A read of 0x6 returns the subsystem number in bits 13:12, the channel number in bits 4:0 and zero elsewhere. The pointer resets to 0.
- R2: A channel number of 24 or more selects no channel. Register writes to 0x0/0x1 are then dropped, and reads of 0x0/0x1 return zero.
- R3: Address 0x0 reads and writes buffer A of the selected channel, and 0x1 does the same for buffer B. A write keeps only `reg_wdata[11:0]`, and a read returns the 12-bit code zero-extended. Buffers reset to zero.
- R4: Immediate mode is configuration bit 15 = 0. A buffer write reaches the matching live register, and therefore `code_out`, at the same clock edge.
- R5: Strobed mode is configuration bit 15 = 1. Buffer writes leave the live registers unchanged. A `load_strobe` copies both buffers into both live registers for every channel of every strobed-mode subsystem. A buffer write in the strobe's cycle is included in that copy. In immediate mode the strobe has no effect.
- R6: Configuration bit 5 = 1 forces every output of that subsystem to zero. The live registers keep their values, and those values return once the bit is cleared.
- R7: Square-wave control bit 0 enables alternation. While it is enabled, each `toggle_strobe` flips the subsystem phase. Phase 0 shows live A and phase 1 shows live B. Disabling alternation returns the phase to 0. While it is disabled, the output is live A.
- R8: Configuration (0x4), square-wave control (0x7), power mode (0x8) and clock divider (0x9) are 16-bit read/write registers per subsystem. They reset to 0x0555, 0x0000, 0xCAFE and 0x0000.
- R9: Address 0x5 always reads 0xFFFF, and writes to it are ignored.
- R10: Addresses 0x2, 0x3 and 0xA to 0xF read zero, and writes to them change nothing.
- R11: Channel c of subsystem s drives `code_out[(s*24+c)*12 +: 12]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address within the selected subsystem |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| ptr_wr | input | 1 | Pointer load enable |
| ptr_wdata | input | 16 | Pointer value (subsystem bits 13:12, channel bits 4:0) |
| load_strobe | input | 1 | Load strobe for strobed-mode subsystems |
| toggle_strobe | input | 1 | Square-wave phase step |
| code_out | output | 1152 | All 96 channel codes, 12 bits each |

## Verification
The bench builds the block with its default parameters: four subsystems of 24 channels and 12-bit codes. With these values the 5-bit channel field can name the unused values 24 to 31, which brings the dropped-access path into reach. With four subsystems, random pointer moves also mix immediate and strobed subsystems, so one load strobe must update some channels and leave others alone. Random traffic across all 96 outputs also checks that clear and square-wave phase stay confined to their own subsystem.

// File: rtl/dac_rb_pkg.sv
package dac_rb_pkg;

    localparam int RB_DATA_W = 16;
    localparam int RB_ADDR_W = 4;

    localparam logic [RB_ADDR_W-1:0] ADR_BUF_A = 4'h0;
    localparam logic [RB_ADDR_W-1:0] ADR_BUF_B = 4'h1;
    localparam logic [RB_ADDR_W-1:0] ADR_CFG   = 4'h4;
    localparam logic [RB_ADDR_W-1:0] ADR_CRC   = 4'h5;
    localparam logic [RB_ADDR_W-1:0] ADR_PTR   = 4'h6;
    localparam logic [RB_ADDR_W-1:0] ADR_SQW   = 4'h7;
    localparam logic [RB_ADDR_W-1:0] ADR_PWR   = 4'h8;
    localparam logic [RB_ADDR_W-1:0] ADR_DIV   = 4'h9;

    localparam int CFG_SYNC_BIT = 15;
    localparam int CFG_CLR_BIT  = 5;
    localparam int SQW_EN_BIT   = 0;
    localparam int PTR_SUB_LSB  = 12;

    localparam logic [RB_DATA_W-1:0] CFG_RST = 16'h0555;
    localparam logic [RB_DATA_W-1:0] SQW_RST = 16'h0000;
    localparam logic [RB_DATA_W-1:0] PWR_RST = 16'hCAFE;
    localparam logic [RB_DATA_W-1:0] DIV_RST = 16'h0000;
    localparam logic [RB_DATA_W-1:0] CRC_VAL = 16'hFFFF;

    typedef struct packed {
        logic [RB_DATA_W-1:0] cfg;
        logic [RB_DATA_W-1:0] sqw;
        logic [RB_DATA_W-1:0] pwr;
        logic [RB_DATA_W-1:0] div;
        logic                 phase;
    } sub_regs_t;

endpackage

// File: rtl/dac_rb_chan.sv
module dac_rb_chan #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [CODE_W-1:0] wcode,
    input  logic              sync_mode,
    input  logic              load,
    input  logic              clear,
    input  logic              sq_en,
    input  logic              phase,
    output logic [CODE_W-1:0] buf_a,
    output logic [CODE_W-1:0] buf_b,
    output logic [CODE_W-1:0] code
);

    typedef struct packed {
        logic [CODE_W-1:0] stage_a;
        logic [CODE_W-1:0] stage_b;
        logic [CODE_W-1:0] live_a;
        logic [CODE_W-1:0] live_b;
    } chan_t;

    chan_t chan_d, chan_q;

    always_comb begin
        chan_d = chan_q;
        if (wr_a) begin
            chan_d.stage_a = wcode;
            if (!sync_mode) chan_d.live_a = wcode;
        end
        if (wr_b) begin
            chan_d.stage_b = wcode;
            if (!sync_mode) chan_d.live_b = wcode;
        end
        if (sync_mode && load) begin
            chan_d.live_a = chan_d.stage_a;
            chan_d.live_b = chan_d.stage_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign buf_a = chan_q.stage_a;
    assign buf_b = chan_q.stage_b;
    assign code  = clear           ? '0 :
                   (sq_en && phase) ? chan_q.live_b : chan_q.live_a;

endmodule

// File: rtl/dac_rb_sub.sv
module dac_rb_sub
    import dac_rb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RB_ADDR_W-1:0] addr,
    input  logic [RB_DATA_W-1:0] wdata,
    input  logic                 toggle,
    output logic [RB_DATA_W-1:0] rdata,
    output logic                 sync_mode,
    output logic                 clear,
    output logic                 sq_en,
    output logic                 phase
);

    sub_regs_t sub_d, sub_q;

    always_comb begin
        sub_d = sub_q;
        if (wr_en) begin
            case (addr)
                ADR_CFG: sub_d.cfg = wdata;
                ADR_SQW: sub_d.sqw = wdata;
                ADR_PWR: sub_d.pwr = wdata;
                ADR_DIV: sub_d.div = wdata;
                default: ;
            endcase
        end
        sub_d.phase = sub_q.sqw[SQW_EN_BIT] ? (sub_q.phase ^ toggle) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q.cfg   <= CFG_RST;
            sub_q.sqw   <= SQW_RST;
            sub_q.pwr   <= PWR_RST;
            sub_q.div   <= DIV_RST;
            sub_q.phase <= 1'b0;
        end else begin
            sub_q <= sub_d;
        end
    end

    always_comb begin
        case (addr)
            ADR_CFG: rdata = sub_q.cfg;
            ADR_SQW: rdata = sub_q.sqw;
            ADR_PWR: rdata = sub_q.pwr;
            ADR_DIV: rdata = sub_q.div;
            default: rdata = '0;
        endcase
    end

    assign sync_mode = sub_q.cfg[CFG_SYNC_BIT];
    assign clear     = sub_q.cfg[CFG_CLR_BIT];
    assign sq_en     = sub_q.sqw[SQW_EN_BIT];
    assign phase     = sub_q.phase;

endmodule

// File: rtl/dac_rb_ptr.sv
module dac_rb_ptr
    import dac_rb_pkg::*;
#(
    parameter int SUB_W = 2,
    parameter int CH_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ptr_wr,
    input  logic [RB_DATA_W-1:0] ptr_wdata,
    output logic [SUB_W-1:0]     sub_sel,
    output logic [CH_W-1:0]      ch_sel,
    output logic [RB_DATA_W-1:0] ptr_rdata
);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [CH_W-1:0]  ch;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic unused_ptr_bits;

    assign unused_ptr_bits = ^{ptr_wdata[RB_DATA_W-1:PTR_SUB_LSB+SUB_W],
                               ptr_wdata[PTR_SUB_LSB-1:CH_W]};

    always_comb begin
        ptr_d = ptr_q;
        if (ptr_wr) begin
            ptr_d.sub = ptr_wdata[PTR_SUB_LSB +: SUB_W];
            ptr_d.ch  = ptr_wdata[CH_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_comb begin
        ptr_rdata                        = '0;
        ptr_rdata[PTR_SUB_LSB +: SUB_W]  = ptr_q.sub;
        ptr_rdata[CH_W-1:0]              = ptr_q.ch;
    end

    assign sub_sel = ptr_q.sub;
    assign ch_sel  = ptr_q.ch;

endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
    import dac_rb_pkg::*;
#(
    parameter int NUM_SUB    = 4,
    parameter int CH_PER_SUB = 24,
    parameter int CODE_W     = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic [3:0]                     reg_addr,
    input  logic [15:0]                    reg_wdata,
    output logic [15:0]                    reg_rdata,
    input  logic                           ptr_wr,
    input  logic [15:0]                    ptr_wdata,
    input  logic                           load_strobe,
    input  logic                           toggle_strobe,
    output logic [NUM_SUB*CH_PER_SUB*CODE_W-1:0] code_out
);

    localparam int SUB_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1;
    localparam int CH_W   = 5;
    localparam int NUM_CH = NUM_SUB * CH_PER_SUB;
    localparam int IDX_W  = $clog2(NUM_CH);

    logic [SUB_W-1:0]     ptr_sub;
    logic [CH_W-1:0]      ptr_ch;
    logic [15:0]          ptr_rdata;
    logic                 ch_valid;
    logic [IDX_W-1:0]     sel_idx;

    logic [NUM_SUB-1:0]   sync_vec;
    logic [NUM_SUB-1:0]   clear_vec;
    logic [NUM_SUB-1:0]   sqen_vec;
    logic [NUM_SUB-1:0]   phase_vec;
    logic [15:0]          sub_rd [NUM_SUB];
    logic [CODE_W-1:0]    rb_a   [NUM_CH];
    logic [CODE_W-1:0]    rb_b   [NUM_CH];

    dac_rb_ptr #(.SUB_W(SUB_W), .CH_W(CH_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_wr    (ptr_wr),
        .ptr_wdata (ptr_wdata),
        .sub_sel   (ptr_sub),
        .ch_sel    (ptr_ch),
        .ptr_rdata (ptr_rdata)
    );

    assign ch_valid = ({1'b0, ptr_ch} < (CH_W+1)'(CH_PER_SUB));
    assign sel_idx  = IDX_W'(int'(ptr_sub) * CH_PER_SUB + int'(ptr_ch));

    for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
        logic sub_hit;
        assign sub_hit = (ptr_sub == SUB_W'(s));

        dac_rb_sub u_sub (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_wr && sub_hit),
            .addr      (reg_addr),
            .wdata     (reg_wdata),
            .toggle    (toggle_strobe),
            .rdata     (sub_rd[s]),
            .sync_mode (sync_vec[s]),
            .clear     (clear_vec[s]),
            .sq_en     (sqen_vec[s]),
            .phase     (phase_vec[s])
        );

        for (genvar c = 0; c < CH_PER_SUB; c++) begin : g_ch
            localparam int K = s * CH_PER_SUB + c;
            logic ch_hit;
            assign ch_hit = reg_wr && sub_hit && (ptr_ch == CH_W'(c));

            dac_rb_chan #(.CODE_W(CODE_W)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_a      (ch_hit && (reg_addr == ADR_BUF_A)),
                .wr_b      (ch_hit && (reg_addr == ADR_BUF_B)),
                .wcode     (reg_wdata[CODE_W-1:0]),
                .sync_mode (sync_vec[s]),
                .load      (load_strobe),
                .clear     (clear_vec[s]),
                .sq_en     (sqen_vec[s]),
                .phase     (phase_vec[s]),
                .buf_a     (rb_a[K]),
                .buf_b     (rb_b[K]),
                .code      (code_out[K*CODE_W +: CODE_W])
            );
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_BUF_A: if (ch_valid) reg_rdata = 16'(rb_a[sel_idx]);
            ADR_BUF_B: if (ch_valid) reg_rdata = 16'(rb_b[sel_idx]);
            ADR_CRC:   reg_rdata = CRC_VAL;
            ADR_PTR:   reg_rdata = ptr_rdata;
            ADR_CFG, ADR_SQW, ADR_PWR, ADR_DIV: reg_rdata = sub_rd[ptr_sub];
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dac_rb_chk.sv
module dac_rb_chk #(
    parameter int NUM_SUB    = 4,
    parameter int CH_PER_SUB = 24,
    parameter int CODE_W     = 12,
    parameter int SUB_W      = 2,
    parameter int CH_W       = 5
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 reg_wr,
    input logic [3:0]                           reg_addr,
    input logic [15:0]                          reg_wdata,
    input logic [15:0]                          reg_rdata,
    input logic                                 ptr_wr,
    input logic                                 load_strobe,
    input logic                                 toggle_strobe,
    input logic [NUM_SUB*CH_PER_SUB*CODE_W-1:0] code_out,
    input logic [SUB_W-1:0]                     ptr_sub,
    input logic [CH_W-1:0]                      ptr_ch,
    input logic [NUM_SUB-1:0]                   sync_vec,
    input logic [NUM_SUB-1:0]                   clear_vec,
    input logic [NUM_SUB-1:0]                   sqen_vec
);

    int   idx;
    logic valid;
    logic reserved;

    assign idx      = int'(ptr_sub) * CH_PER_SUB + int'(ptr_ch);
    assign valid    = int'(ptr_ch) < CH_PER_SUB;
    assign reserved = (reg_addr == 4'h2) || (reg_addr == 4'h3) || (reg_addr >= 4'hA);

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reserved |-> reg_rdata == 16'h0);

    // R9
    crc_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'h5) |-> reg_rdata == 16'hFFFF);

    // R2
    bad_ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && reg_addr <= 4'h1) |-> reg_rdata == 16'h0);

    // R1
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_wr |=> ($stable(ptr_sub) && $stable(ptr_ch)));

    // R4
    async_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'h0 && valid && !sync_vec[ptr_sub] &&
         !clear_vec[ptr_sub] && !sqen_vec[ptr_sub])
        |=> code_out[$past(idx)*CODE_W +: CODE_W] == $past(reg_wdata[CODE_W-1:0]));

    // R5
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !load_strobe && !toggle_strobe) |=> $stable(code_out));

endmodule

bind dac_regbank dac_rb_chk #(
    .NUM_SUB    (NUM_SUB),
    .CH_PER_SUB (CH_PER_SUB),
    .CODE_W     (CODE_W),
    .SUB_W      (SUB_W),
    .CH_W       (CH_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .ptr_wr        (ptr_wr),
    .load_strobe   (load_strobe),
    .toggle_strobe (toggle_strobe),
    .code_out      (code_out),
    .ptr_sub       (ptr_sub),
    .ptr_ch        (ptr_ch),
    .sync_vec      (sync_vec),
    .clear_vec     (clear_vec),
    .sqen_vec      (sqen_vec)
);

// File: tb/tb_dac_regbank.sv
module tb_dac_regbank;

    localparam int NS  = 4;
    localparam int CPS = 24;
    localparam int NCH = NS * CPS;
    localparam int CW  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic              ptr_wr = 1'b0;
    logic [15:0]       ptr_wdata = '0;
    logic              load_strobe = 1'b0;
    logic              toggle_strobe = 1'b0;
    logic [NCH*CW-1:0] code_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_cfg [NS];
    logic [15:0] m_sqw [NS];
    logic [15:0] m_pwr [NS];
    logic [15:0] m_div [NS];
    logic        m_ph  [NS];
    logic [CW-1:0] m_sa [NCH];
    logic [CW-1:0] m_sb [NCH];
    logic [CW-1:0] m_la [NCH];
    logic [CW-1:0] m_lb [NCH];
    int m_sub = 0;
    int m_ch  = 0;

    dac_regbank dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ptr_wr        (ptr_wr),
        .ptr_wdata     (ptr_wdata),
        .load_strobe   (load_strobe),
        .toggle_strobe (toggle_strobe),
        .code_out      (code_out)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        int k;
        k = m_sub * CPS + m_ch;
        case (a)
            4'h0: return (m_ch < CPS) ? 16'(m_sa[k]) : 16'h0;
            4'h1: return (m_ch < CPS) ? 16'(m_sb[k]) : 16'h0;
            4'h4: return m_cfg[m_sub];
            4'h5: return 16'hFFFF;
            4'h6: return 16'((m_sub << 12) | m_ch);
            4'h7: return m_sqw[m_sub];
            4'h8: return m_pwr[m_sub];
            4'h9: return m_div[m_sub];
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [CW-1:0] exp_code(input int k);
        int s;
        s = k / CPS;
        if (m_cfg[s][5])               return '0;
        if (m_sqw[s][0] && m_ph[s])    return m_lb[k];
        return m_la[k];
    endfunction

    function automatic string rtag(input logic [3:0] a);
        case (a)
            4'h0, 4'h1: return (m_ch < CPS) ? "R3" : "R2";
            4'h4, 4'h7, 4'h8, 4'h9: return "R8";
            4'h5: return "R9";
            4'h6: return "R1";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic old_sync [NS];
        logic old_en   [NS];
        int k;
        for (int s = 0; s < NS; s++) begin
            old_sync[s] = m_cfg[s][15];
            old_en[s]   = m_sqw[s][0];
        end
        k = m_sub * CPS + m_ch;
        if (reg_wr && m_ch < CPS && reg_addr == 4'h0) begin
            m_sa[k] = reg_wdata[CW-1:0];
            if (!old_sync[m_sub]) m_la[k] = reg_wdata[CW-1:0];
        end
        if (reg_wr && m_ch < CPS && reg_addr == 4'h1) begin
            m_sb[k] = reg_wdata[CW-1:0];
            if (!old_sync[m_sub]) m_lb[k] = reg_wdata[CW-1:0];
        end
        if (reg_wr) begin
            case (reg_addr)
                4'h4: m_cfg[m_sub] = reg_wdata;
                4'h7: m_sqw[m_sub] = reg_wdata;
                4'h8: m_pwr[m_sub] = reg_wdata;
                4'h9: m_div[m_sub] = reg_wdata;
                default: ;
            endcase
        end
        for (int s = 0; s < NS; s++)
            m_ph[s] = old_en[s] ? (m_ph[s] ^ toggle_strobe) : 1'b0;
        if (load_strobe) begin
            for (int j = 0; j < NCH; j++) begin
                if (old_sync[j / CPS]) begin
                    m_la[j] = m_sa[j];
                    m_lb[j] = m_sb[j];
                end
            end
        end
        if (ptr_wr) begin
            m_sub = int'(ptr_wdata[13:12]);
            m_ch  = int'(ptr_wdata[4:0]);
        end
    endtask

    task automatic check_outputs(input string tag);
        int bad;
        bad = -1;
        for (int j = 0; j < NCH; j++)
            if (bad < 0 && code_out[j*CW +: CW] !== exp_code(j)) bad = j;
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, $sformatf("%s slot %0d", tag, bad),
                 32'(code_out[bad*CW +: CW]), 32'(exp_code(bad)));
    endtask

    // Called at a falling edge: drive, check read, clock, update model, check outputs.
    task automatic step(input bit wr, input logic [3:0] a, input logic [15:0] wd,
                        input bit pw, input logic [15:0] pd, input bit ld, input bit tg,
                        input string otag);
        string t;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        ptr_wr = pw; ptr_wdata = pd; load_strobe = ld; toggle_strobe = tg;
        #1;
        t = rtag(a);
        chk(reg_rdata === exp_read(a), t, 32'(reg_rdata), 32'(exp_read(a)));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_outputs(otag);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] wd, input string otag);
        step(1'b1, a, wd, 1'b0, 16'h0, 1'b0, 1'b0, otag);
    endtask

    task automatic rd_reg(input logic [3:0] a, input string otag);
        step(1'b0, a, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, otag);
    endtask

    task automatic set_ptr(input int s, input int c);
        step(1'b0, 4'h6, 16'h0, 1'b1, 16'((s << 12) | c), 1'b0, 1'b0, "R1");
    endtask

    task automatic chk_slot(input int k, input logic [CW-1:0] e, input string tag);
        chk(code_out[k*CW +: CW] === e, tag, 32'(code_out[k*CW +: CW]), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] pick [12];
        int seed;
        pick = '{4'h0, 4'h1, 4'h0, 4'h1, 4'h4, 4'h7, 4'h5, 4'h6, 4'h2, 4'h8, 4'h9, 4'hC};
        seed = $urandom(32'd20240611);
        for (int s = 0; s < NS; s++) begin
            m_cfg[s] = 16'h0555; m_sqw[s] = 16'h0; m_pwr[s] = 16'hCAFE;
            m_div[s] = 16'h0;    m_ph[s]  = 1'b0;
        end
        for (int j = 0; j < NCH; j++) begin
            m_sa[j] = '0; m_sb[j] = '0; m_la[j] = '0; m_lb[j] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state of every address (R1 R3 R8 R9 R10) and outputs (R11)
        for (int a = 0; a < 16; a++) rd_reg(4'(a), "R11");

        // R1 pointer load, R4 immediate update, R11 slot position
        set_ptr(2, 5);
        rd_reg(4'h6, "R1");
        wr_reg(4'h0, 16'hABCD, "R4");
        chk_slot(2*CPS+5, 12'hBCD, "R4");
        wr_reg(4'h6, 16'h3011, "R1");
        rd_reg(4'h6, "R1");

        // R2 out-of-range channel
        set_ptr(2, 30);
        wr_reg(4'h0, 16'h0123, "R2");
        rd_reg(4'h0, "R2");
        set_ptr(2, 5);
        rd_reg(4'h0, "R2");
        chk(reg_rdata === 16'h0BCD, "R2", 32'(reg_rdata), 32'h0BCD);

        // R5 strobed update
        wr_reg(4'h4, 16'h8555, "R5");
        wr_reg(4'h0, 16'h0456, "R5");
        chk_slot(2*CPS+5, 12'hBCD, "R5");
        step(1'b1, 4'h1, 16'h0789, 1'b0, 16'h0, 1'b1, 1'b0, "R5");
        chk_slot(2*CPS+5, 12'h456, "R5");

        // R6 clear override and release
        wr_reg(4'h4, 16'h0575, "R6");
        chk_slot(2*CPS+5, 12'h000, "R6");
        wr_reg(4'h4, 16'h0555, "R6");
        chk_slot(2*CPS+5, 12'h456, "R6");

        // R7 square-wave alternation
        wr_reg(4'h7, 16'h0001, "R7");
        step(1'b0, 4'h7, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1, "R7");
        chk_slot(2*CPS+5, 12'h789, "R7");
        step(1'b0, 4'h7, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1, "R7");
        chk_slot(2*CPS+5, 12'h456, "R7");
        step(1'b0, 4'h7, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1, "R7");
        wr_reg(4'h7, 16'h0000, "R7");
        chk_slot(2*CPS+5, 12'h456, "R7");

        // R8 R9 R10 register behaviour
        wr_reg(4'h8, 16'h1234, "R8");
        rd_reg(4'h8, "R8");
        wr_reg(4'h5, 16'h0000, "R9");
        rd_reg(4'h5, "R9");
        wr_reg(4'hB, 16'hFFFF, "R10");
        rd_reg(4'hB, "R10");

        // Random traffic
        for (int i = 0; i < 5000; i++) begin
            bit wr, pw, ld, tg;
            logic [3:0]  a;
            logic [15:0] wd, pd;
            wr = ($urandom % 2) == 0;
            pw = ($urandom % 10) == 0;
            ld = ($urandom % 10) == 0;
            tg = ($urandom % 5) == 0;
            a  = pick[$urandom % 12];
            wd = 16'($urandom);
            if (a == 4'h4 && ($urandom % 4) != 0) wd[5] = 1'b0;
            pd = 16'($urandom);
            step(wr, a, wd, pw, pd, ld, tg, "R11");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule